// File: doc/BRIEF.md
# Sub-Array Refresh Row Address Front End

This block sits in front of one DRAM bank's row decoding and lets a refresh proceed in one sub-array while a normal activation is served in another. It holds two row address registers, one for the activation path and one for the refresh path. Each sub-array has its own multiplexer that picks which of the two registers drives its row address. While a refresh is in progress, the refreshing sub-array takes the refresh register, and its column select is inhibited so no data reaches the shared I/O. Every other sub-array keeps taking the activation register.

An internal counter supplies refresh addresses. It steps through the sub-arrays before it steps the inner row, so consecutive refreshes land in different sub-arrays. The bank's sub-rank select qualifies each refresh command. A row address is the concatenation {sub-array index, inner row}. The sub-array index is in the upper bits. The number of logical sub-arrays and the number of rows in each are parameters. Several physical 512-row sub-arrays may be grouped into one logical sub-array.

Top module: `subarray_refresh_rowfe`

## Requirements
- R1: After a synchronous active-high reset, all row outputs, busy flags, inhibit flags, wordline flags and the conflict flag are zero, and the refresh counter points at sub-array 0, inner row 0.
- R2: A refresh command accepted at a clock edge latches the counter value into the refresh register. From the next cycle, the target sub-array's row output shows that value.
- R3: After each accepted refresh, the counter advances the sub-array index by one. Only when the index wraps from the last sub-array to 0 does the inner row advance by one, and the inner row also wraps.
- R4: A refresh stays in progress for exactly TRFC cycles. During that time exactly the target sub-array has its column-select inhibit bit set, and no other inhibit bit is set.
- R5: A refresh is an open phase followed by a precharge phase. The target's wordline flag is high for the first TRFC-TRP cycles of the refresh and low for the last TRP cycles.
- R6: When the refresh count expires, the target sub-array's multiplexer returns to the activation register, and its row output shows the activation row address.
- R7: An activation while no row is open latches the row address. It sets the busy and wordline flags of the sub-array in the upper row bits until a precharge. An activation while a row is open is ignored. A precharge with no open row has no effect.
- R8: An activation is ignored when its sub-array equals the one under refresh, or the one whose refresh is accepted in the same cycle. In that case the conflict flag is high for the single following cycle.
- R9: An activation to any other sub-array is served while a refresh is in progress.
- R10: A refresh command is ignored when the sub-rank select is low or a refresh is already in progress. In that case the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Activate command |
| pre_i | input | 1 | Precharge command |
| ref_i | input | 1 | Refresh command |
| subrank_sel_i | input | 1 | This bank's sub-rank is addressed by the refresh |
| act_row_i | input | ROW_W | Activation row address {sub-array, inner row} |
| sa_row_o | output | NUM_SUB*ROW_W | Row address driven to each sub-array, sub-array i at bits [i*ROW_W +: ROW_W] |
| sa_busy_o | output | NUM_SUB | Sub-array is refreshing or holds the open row |
| sa_wl_o | output | NUM_SUB | Wordline of the sub-array is raised |
| sa_csl_inhibit_o | output | NUM_SUB | Column select blocked for the sub-array |
| act_conflict_o | output | 1 | Activation was dropped because of a sub-array clash |

## Verification
The hardest case to reach is an activation that targets the sub-array whose refresh is being accepted in the same cycle. Here the clash comes from the counter's value at that edge, not from a refresh already visible at the outputs. The bench issues refresh and activation commands in the same cycle with row addresses drawn from a small space. It also runs long random mixes, so each sub-array index, including the wrap of the counter, meets both a concurrent activation and a clashing one. A behavioural model tracks the counter as plain integers and predicts every output on every cycle.

// File: rtl/sarf_pkg.sv
package sarf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_OPEN  = 2'd1,
    PH_CLOSE = 2'd2
  } ref_phase_t;
endpackage

// File: rtl/sarf_refresh_ctr.sv
module sarf_refresh_ctr
  import sarf_pkg::*;
#(
  parameter int NUM_SUB      = 8,
  parameter int ROWS_PER_SUB = 4,
  parameter int TRFC         = 8,
  parameter int TRP          = 3,
  localparam int SA_W  = $clog2(NUM_SUB),
  localparam int IN_W  = $clog2(ROWS_PER_SUB),
  localparam int ROW_W = SA_W + IN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_i,
  input  logic             sel_i,
  output logic             accept_o,
  output logic             active_o,
  output ref_phase_t       phase_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic [SA_W-1:0]  next_sa_o
);
  localparam int TM_W = $clog2(TRFC);

  logic [SA_W-1:0]  cnt_sa;
  logic [IN_W-1:0]  cnt_in;
  logic [ROW_W-1:0] ref_row;
  logic [TM_W-1:0]  timer;
  logic             active;

  assign accept_o  = ref_i && sel_i && !active;
  assign active_o  = active;
  assign ref_row_o = ref_row;
  assign next_sa_o = cnt_sa;

  always_comb begin
    if (!active)                  phase_o = PH_IDLE;
    else if (timer >= TM_W'(TRP)) phase_o = PH_OPEN;
    else                          phase_o = PH_CLOSE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_sa  <= '0;
      cnt_in  <= '0;
      ref_row <= '0;
      timer   <= '0;
      active  <= 1'b0;
    end else if (active) begin
      if (timer == '0) active <= 1'b0;
      else             timer  <= timer - 1'b1;
    end else if (accept_o) begin
      active  <= 1'b1;
      timer   <= TM_W'(TRFC - 1);
      ref_row <= {cnt_sa, cnt_in};
      cnt_sa  <= cnt_sa + 1'b1;
      if (cnt_sa == SA_W'(NUM_SUB - 1)) cnt_in <= cnt_in + 1'b1;
    end
  end

  initial begin
    assert (TRFC > TRP && TRP >= 1);
    assert ((1 << SA_W) == NUM_SUB && NUM_SUB >= 2);
    assert ((1 << IN_W) == ROWS_PER_SUB && ROWS_PER_SUB >= 2);
  end

  a_r4_expire: assert property (@(posedge clk) disable iff (rst)
    (active && timer == '0) |=> !active);
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> (cnt_sa != $past(cnt_sa)));
  a_r10_no_sel: assert property (@(posedge clk) disable iff (rst)
    (!active && !(ref_i && sel_i)) |=> (!active && $stable(cnt_sa) && $stable(cnt_in)));
endmodule

// File: rtl/sarf_act_reg.sv
module sarf_act_reg #(
  parameter int SA_W  = 3,
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic             blk_valid_i,
  input  logic [SA_W-1:0]  blk_sa_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             err_o
);
  logic clash;
  assign clash = blk_valid_i && (act_row_i[ROW_W-1 -: SA_W] == blk_sa_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o <= 1'b0;
      row_o  <= '0;
      err_o  <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (open_o) begin
        if (pre_i) open_o <= 1'b0;
      end else if (act_i) begin
        if (clash) err_o <= 1'b1;
        else begin
          open_o <= 1'b1;
          row_o  <= act_row_i;
        end
      end
    end
  end

  a_r8_conflict_ignored: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (open_o == $past(open_o)));
  a_r7_act_when_open: assert property (@(posedge clk) disable iff (rst)
    (open_o && !pre_i) |=> (open_o && $stable(row_o)));
endmodule

// File: rtl/subarray_refresh_rowfe.sv
module subarray_refresh_rowfe
  import sarf_pkg::*;
#(
  parameter int NUM_SUB      = 8,
  parameter int ROWS_PER_SUB = 4,
  parameter int TRFC         = 8,
  parameter int TRP          = 3,
  localparam int SA_W  = $clog2(NUM_SUB),
  localparam int ROW_W = SA_W + $clog2(ROWS_PER_SUB)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     act_i,
  input  logic                     pre_i,
  input  logic                     ref_i,
  input  logic                     subrank_sel_i,
  input  logic [ROW_W-1:0]         act_row_i,
  output logic [NUM_SUB*ROW_W-1:0] sa_row_o,
  output logic [NUM_SUB-1:0]       sa_busy_o,
  output logic [NUM_SUB-1:0]       sa_wl_o,
  output logic [NUM_SUB-1:0]       sa_csl_inhibit_o,
  output logic                     act_conflict_o
);
  logic             ref_accept, ref_active;
  ref_phase_t       ref_phase;
  logic [ROW_W-1:0] ref_row, act_row;
  logic [SA_W-1:0]  next_sa, ref_sa, act_sa, blk_sa;
  logic             act_open;

  sarf_refresh_ctr #(
    .NUM_SUB(NUM_SUB), .ROWS_PER_SUB(ROWS_PER_SUB), .TRFC(TRFC), .TRP(TRP)
  ) u_ref (
    .clk(clk), .rst(rst), .ref_i(ref_i), .sel_i(subrank_sel_i),
    .accept_o(ref_accept), .active_o(ref_active), .phase_o(ref_phase),
    .ref_row_o(ref_row), .next_sa_o(next_sa)
  );

  assign ref_sa = ref_row[ROW_W-1 -: SA_W];
  assign blk_sa = ref_active ? ref_sa : next_sa;

  sarf_act_reg #(.SA_W(SA_W), .ROW_W(ROW_W)) u_act (
    .clk(clk), .rst(rst), .act_i(act_i), .pre_i(pre_i), .act_row_i(act_row_i),
    .blk_valid_i(ref_active || ref_accept), .blk_sa_i(blk_sa),
    .open_o(act_open), .row_o(act_row), .err_o(act_conflict_o)
  );

  assign act_sa = act_row[ROW_W-1 -: SA_W];

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_sub
    logic use_ref, holds_act;
    assign use_ref   = ref_active && (ref_sa == SA_W'(i));
    assign holds_act = act_open && (act_sa == SA_W'(i));
    assign sa_row_o[i*ROW_W +: ROW_W] = use_ref ? ref_row : act_row;
    assign sa_busy_o[i]        = use_ref || holds_act;
    assign sa_csl_inhibit_o[i] = use_ref;
    assign sa_wl_o[i]          = (use_ref && ref_phase == PH_OPEN) || holds_act;
  end

  a_r4_inhibit_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sa_csl_inhibit_o));
  a_r9_busy_limit: assert property (@(posedge clk) disable iff (rst)
    $countones(sa_busy_o) <= 2);
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_active) |-> (sa_csl_inhibit_o == '0));
endmodule

// File: tb/subarray_refresh_rowfe_tb_top.sv
module subarray_refresh_rowfe_tb_top;
  localparam int NS = 8, RPS = 4, TRFC = 8, TRP = 3, RW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic act_i = 0, pre_i = 0, ref_i = 0, sel_i = 0;
  logic [RW-1:0] act_row_i = '0;
  logic [NS*RW-1:0] sa_row_o;
  logic [NS-1:0] sa_busy_o, sa_wl_o, sa_csl_inhibit_o;
  logic act_conflict_o;

  always #10 clk = ~clk;

  subarray_refresh_rowfe #(.NUM_SUB(NS), .ROWS_PER_SUB(RPS), .TRFC(TRFC), .TRP(TRP)) dut_i (
    .clk(clk), .rst(rst), .act_i(act_i), .pre_i(pre_i), .ref_i(ref_i),
    .subrank_sel_i(sel_i), .act_row_i(act_row_i), .sa_row_o(sa_row_o),
    .sa_busy_o(sa_busy_o), .sa_wl_o(sa_wl_o), .sa_csl_inhibit_o(sa_csl_inhibit_o),
    .act_conflict_o(act_conflict_o)
  );

  int checks = 0, errors = 0;
  bit started = 0;

  // behavioural reference
  int m_cnt_sa, m_cnt_in, m_ref_row, m_active, m_timer, m_open, m_act_row, m_err;
  always @(posedge clk) begin
    int acc, bv, bs, asa;
    if (rst) begin
      m_cnt_sa = 0; m_cnt_in = 0; m_ref_row = 0; m_active = 0;
      m_timer = 0; m_open = 0; m_act_row = 0; m_err = 0;
    end else begin
      acc = (ref_i && sel_i && m_active == 0) ? 1 : 0;
      bv  = (m_active != 0 || acc != 0) ? 1 : 0;
      bs  = (m_active != 0) ? m_ref_row / RPS : m_cnt_sa;
      asa = int'(act_row_i) / RPS;
      m_err = 0;
      if (m_open != 0) begin
        if (pre_i) m_open = 0;
      end else if (act_i) begin
        if (bv != 0 && asa == bs) m_err = 1;
        else begin m_open = 1; m_act_row = int'(act_row_i); end
      end
      if (m_active != 0) begin
        if (m_timer == 0) m_active = 0; else m_timer = m_timer - 1;
      end else if (acc != 0) begin
        m_active = 1; m_timer = TRFC - 1;
        m_ref_row = m_cnt_sa * RPS + m_cnt_in;
        if (m_cnt_sa == NS - 1) m_cnt_in = (m_cnt_in + 1) % RPS;
        m_cnt_sa = (m_cnt_sa + 1) % NS;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [NS*RW-1:0] e_row;
    logic [NS-1:0] e_busy, e_wl, e_csl;
    if (started) begin
      for (int i = 0; i < NS; i++) begin
        bit r, a;
        r = (m_active != 0) && (m_ref_row / RPS == i);
        a = (m_open != 0) && (m_act_row / RPS == i);
        e_row[i*RW +: RW] = r ? RW'(m_ref_row) : RW'(m_act_row);
        e_busy[i] = r | a;
        e_csl[i]  = r;
        e_wl[i]   = (r && m_timer >= TRP) | a;
      end
      chk("R6 row outputs", 64'(sa_row_o), 64'(e_row));
      chk("R7 busy", 64'(sa_busy_o), 64'(e_busy));
      chk("R4 inhibit", 64'(sa_csl_inhibit_o), 64'(e_csl));
      chk("R5 wordline", 64'(sa_wl_o), 64'(e_wl));
      chk("R8 conflict", 64'(act_conflict_o), 64'(m_err));
    end
  end

  task automatic drive(bit a, bit p, bit r, bit s, int row);
    act_i = a; pre_i = p; ref_i = r; sel_i = s; act_row_i = RW'(row);
    @(negedge clk);
    act_i = 0; pre_i = 0; ref_i = 0; sel_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk); started = 1;
    repeat (2) @(negedge clk);
    chk("R1 reset rows", 64'(sa_row_o), 64'd0);
    chk("R1 reset flags", 64'({sa_busy_o, sa_wl_o, sa_csl_inhibit_o, act_conflict_o}), 64'd0);
    rst = 0;
    @(negedge clk);
    // first refresh goes to sub-array 0 row 0
    drive(0, 0, 1, 1, 0);
    chk("R2 target inhibit", 64'(sa_csl_inhibit_o), 64'h01);
    chk("R2 target row", 64'(sa_row_o[0 +: RW]), 64'd0);
    drive(1, 0, 0, 0, 2);            // sub-array 0 under refresh: clash
    chk("R8 clash flag", 64'(act_conflict_o), 64'd1);
    drive(1, 0, 0, 0, 13);           // sub-array 3: concurrent
    chk("R9 concurrent busy", 64'(sa_busy_o), 64'h09);
    idle(TRFC);
    chk("R6 mux back", 64'(sa_row_o[0 +: RW]), 64'd13);
    drive(1, 0, 0, 0, 20);           // ignored, row open
    chk("R7 open kept", 64'(sa_row_o[3*RW +: RW]), 64'd13);
    drive(0, 1, 0, 0, 0);
    drive(0, 0, 1, 0, 0);            // no select
    chk("R10 no select", 64'(sa_csl_inhibit_o), 64'd0);
    // counter order across wrap
    for (int k = 1; k < 2 * NS + 2; k++) begin
      int sa;
      sa = k % NS;
      drive(0, 0, 1, 1, 0);
      chk("R3 order inhibit", 64'(sa_csl_inhibit_o), 64'(1) << sa);
      chk("R3 order row", 64'(sa_row_o[sa*RW +: RW]), 64'(sa * RPS + (k / NS) % RPS));
      drive(0, 0, 1, 1, 0);          // during refresh: ignored
      idle(TRFC);
      chk("R10 busy ignore", 64'(sa_csl_inhibit_o), 64'd0);
    end
    // same-cycle accept clash (counter now at sub-array 2)
    drive(1, 0, 1, 1, 2 * RPS + 1);
    chk("R8 same-cycle clash", 64'(act_conflict_o), 64'd1);
    idle(TRFC + 1);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      drive($urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
            $urandom_range(0, 5) == 0, $urandom_range(0, 3) != 0,
            int'($urandom_range(0, NS * RPS - 1)));
    end
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule